// File: doc/BRIEF.md
# USB Bulk/Interrupt Endpoint Packet-Ready Handshake Controller

This block runs the packet-level ownership handshake for a single bulk or interrupt endpoint of a USB device. It sits between the device protocol engine (which has already decoded tokens, checked CRC and framed the data bytes) and the local microcontroller's register interface. Each direction owns a one-packet buffer and a packet-ready status bit. Whichever side holds that bit owns the buffer.

For the device-to-host direction, the microcontroller fills the transmit buffer byte by byte and then sets transmit-ready. An IN token then streams the stored packet to the protocol engine. If transmit-ready is clear, the token gets a NAK. A host ACK that follows a completed send hands the endpoint back: the packet is released, transmit-ready clears and a transmit interrupt pulse asks for the next packet. If the host sends another IN without acknowledging, the same packet goes out again.

For the host-to-device direction, the bytes that follow an OUT token are written into the receive buffer. A clean end of packet is acknowledged, and receive-ready and a receive interrupt pulse are raised on that same cycle. An errored or oversized packet gets no handshake and its buffer is rewound. A packet that arrives while receive-ready is still set is discarded and NAKed. The microcontroller reads the bytes in order and then clears receive-ready.

Top module: `usb_ep_handshake`

## Requirements
- R1: After reset, tx_pkt_ready, rx_pkt_ready, rx_count, txd_valid, txd_zlp, hs_ack, hs_nak, irq, irq_tx and irq_rx are all 0.
- R2: While tx_pkt_ready is 0, each cycle with mcu_tx_wr high appends mcu_tx_wdata to the transmit packet, up to DEPTH bytes. A cycle with mcu_tx_set high sets tx_pkt_ready. Writes made while tx_pkt_ready is 1 are ignored.
- R3: An IN token (tok_in high for one cycle) seen while tx_pkt_ready is 1 starts a send on the next cycle. txd_valid is high and txd_data carries the bytes in write order. The engine advances to the next byte with txd_take, and txd_last marks the final byte. A zero-byte packet instead gives a one-cycle txd_zlp pulse with txd_valid kept low.
- R4: An IN token seen while tx_pkt_ready is 0 gives a one-cycle hs_nak pulse on the next cycle, and txd_valid stays 0.
- R5: host_ack seen after a send (or zero-length send) has completed does three things on the next cycle: tx_pkt_ready goes to 0, the transmit buffer is emptied, and irq_tx and irq pulse for one cycle. host_ack at any other time has no effect.
- R6: An IN token after a completed send and before host_ack resends the same packet from its first byte.
- R7: After an OUT token, rxd_valid bytes are stored in order. A clean rxd_eop gives hs_ack, irq_rx and irq on the next cycle, and rx_pkt_ready rises on that same cycle, with rx_count equal to the byte count.
- R8: While rx_pkt_ready is 1, mcu_rx_rdata shows the next unread byte (0 once all bytes are read) and mcu_rx_rd advances to the following byte. mcu_rx_clr sets rx_pkt_ready and rx_count to 0.
- R9: An OUT packet that arrives while rx_pkt_ready is 1 and ends cleanly gets a one-cycle hs_nak. Its bytes are discarded, and the stored packet and rx_count are unchanged.
- R10: A received packet that ends with rxd_err high, or that carried more than DEPTH bytes, gets neither hs_ack nor hs_nak. rx_count returns to 0 and rx_pkt_ready stays 0.
- R11: irq is high exactly when irq_tx or irq_rx is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mcu_tx_wr | input | 1 | Microcontroller writes one transmit byte |
| mcu_tx_wdata | input | DATA_W | Transmit byte to write |
| mcu_tx_set | input | 1 | Microcontroller sets transmit packet-ready |
| mcu_rx_rd | input | 1 | Microcontroller consumes one receive byte |
| mcu_rx_rdata | output | DATA_W | Next unread receive byte |
| mcu_rx_clr | input | 1 | Microcontroller clears receive packet-ready |
| tx_pkt_ready | output | 1 | Transmit packet-ready status |
| rx_pkt_ready | output | 1 | Receive packet-ready status |
| rx_count | output | CNT_W | Bytes held in the receive buffer |
| irq | output | 1 | Combined interrupt pulse |
| irq_tx | output | 1 | Transmit-side interrupt pulse |
| irq_rx | output | 1 | Receive-side interrupt pulse |
| tok_in | input | 1 | IN token addressed to this endpoint |
| tok_out | input | 1 | OUT token addressed to this endpoint |
| host_ack | input | 1 | ACK handshake received from host |
| rxd_valid | input | 1 | Received data byte strobe |
| rxd_data | input | DATA_W | Received data byte |
| rxd_eop | input | 1 | End of received data packet |
| rxd_err | input | 1 | CRC or length error, qualified by rxd_eop |
| txd_valid | output | 1 | Transmit byte available |
| txd_data | output | DATA_W | Transmit byte |
| txd_last | output | 1 | Current transmit byte is the last |
| txd_take | input | 1 | Engine has taken the current byte |
| txd_zlp | output | 1 | Send a zero-length data packet |
| hs_ack | output | 1 | Device answers ACK |
| hs_nak | output | 1 | Device answers NAK |

## Verification
The transmit side is swept over every packet length from zero to a full buffer, with a byte pattern that depends on both the length and the index. This separates ordering errors, stale bytes left over from the previous packet and wrong last-byte marking. Odd lengths are resent without an ACK to separate restarting the send from continuing it, and stray ACKs before a send show whether the release is gated. The receive side is swept over lengths up to one past the buffer depth, each with and without an error flag, so acknowledge, silent rewind and overflow are each told apart. Every good packet is then followed by a second packet that must be NAKed without disturbing the stored bytes.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

   typedef enum logic [1:0] {
      TXS_IDLE = 2'd0,
      TXS_SEND = 2'd1,
      TXS_WAIT = 2'd2
   } tx_state_e;

   typedef enum logic [1:0] {
      RXS_IDLE = 2'd0,
      RXS_RECV = 2'd1,
      RXS_DROP = 2'd2
   } rx_state_e;

endpackage

// File: rtl/ep_pkt_buf.sv
module ep_pkt_buf #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ep_pkt_buf: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("ep_pkt_buf: DATA_W must be at least 1");
   end

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DEPTH-1:0]  hit;

   for (genvar g = 0; g < DEPTH; g++) begin : g_dec
      assign hit[g] = wr_en && (wr_idx == IDX_W'(g));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
      end else begin
         for (int k = 0; k < DEPTH; k++) begin
            if (hit[k]) mem_q[k] <= wr_data;
         end
      end
   end

   assign rd_data = ({1'b0, rd_idx} < (IDX_W+1)'(DEPTH)) ? mem_q[rd_idx] : '0;

   assert_one_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

endmodule

// File: rtl/ep_tx_path.sv
module ep_tx_path
   import usb_ep_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mcu_wr,
   input  logic [DATA_W-1:0] mcu_wdata,
   input  logic              mcu_set,
   input  logic              tok_in,
   input  logic              host_ack,
   input  logic              take,
   output logic              ready,
   output logic              valid,
   output logic [DATA_W-1:0] data,
   output logic              last,
   output logic              zlp,
   output logic              nak,
   output logic              irq
);

   tx_state_e        st_q;
   logic [CNT_W-1:0] len_q;
   logic [CNT_W-1:0] pos_q;
   logic             rdy_q, nak_q, zlp_q, irq_q;
   logic             load_ok, at_last, can_start;

   assign load_ok   = mcu_wr && !rdy_q && (len_q < CNT_W'(DEPTH));
   assign at_last   = (pos_q == len_q - CNT_W'(1));
   assign can_start = tok_in && (st_q != TXS_SEND);

   ep_pkt_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (load_ok),
      .wr_idx  (len_q[IDX_W-1:0]),
      .wr_data (mcu_wdata),
      .rd_idx  (pos_q[IDX_W-1:0]),
      .rd_data (data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= TXS_IDLE;
         len_q <= '0;
         pos_q <= '0;
         rdy_q <= 1'b0;
         nak_q <= 1'b0;
         zlp_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         nak_q <= 1'b0;
         zlp_q <= 1'b0;
         irq_q <= 1'b0;
         if (load_ok) len_q <= len_q + CNT_W'(1);
         if (mcu_set && !rdy_q) rdy_q <= 1'b1;
         if (can_start) begin
            if (rdy_q) begin
               pos_q <= '0;
               if (len_q == '0) begin
                  zlp_q <= 1'b1;
                  st_q  <= TXS_WAIT;
               end else begin
                  st_q  <= TXS_SEND;
               end
            end else begin
               nak_q <= 1'b1;
            end
         end else if (st_q == TXS_SEND) begin
            if (take) begin
               if (at_last) st_q  <= TXS_WAIT;
               else         pos_q <= pos_q + CNT_W'(1);
            end
         end else if (st_q == TXS_WAIT && host_ack) begin
            rdy_q <= 1'b0;
            len_q <= '0;
            pos_q <= '0;
            irq_q <= 1'b1;
            st_q  <= TXS_IDLE;
         end
      end
   end

   assign ready = rdy_q;
   assign valid = (st_q == TXS_SEND);
   assign last  = valid && at_last;
   assign zlp   = zlp_q;
   assign nak   = nak_q;
   assign irq   = irq_q;

   assert_nak_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      nak_q |-> !valid && !zlp_q);
   assert_send_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> rdy_q && (len_q != '0));
   assert_ack_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TXS_WAIT && host_ack && !tok_in) |=> (!rdy_q && irq_q && len_q == '0));
   assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> !rdy_q && $past(rdy_q));
   assert_locked_fifo_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_q && mcu_wr && !(st_q == TXS_WAIT && host_ack)) |=> $stable(len_q));
   assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      len_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/ep_rx_path.sv
module ep_rx_path
   import usb_ep_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_out,
   input  logic              byte_valid,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              eop,
   input  logic              err,
   input  logic              mcu_rd,
   input  logic              mcu_clr,
   output logic [DATA_W-1:0] mcu_rdata,
   output logic              ready,
   output logic [CNT_W-1:0]  count,
   output logic              ack,
   output logic              nak,
   output logic              irq
);

   rx_state_e         st_q;
   logic [CNT_W-1:0]  len_q;
   logic [CNT_W-1:0]  rpos_q;
   logic              rdy_q, ovf_q, ack_q, nak_q, irq_q;
   logic              store, has_more;
   logic [DATA_W-1:0] buf_rd;

   assign store    = (st_q == RXS_RECV) && byte_valid && !eop && (len_q < CNT_W'(DEPTH));
   assign has_more = rdy_q && (rpos_q < len_q);

   ep_pkt_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (store),
      .wr_idx  (len_q[IDX_W-1:0]),
      .wr_data (byte_data),
      .rd_idx  (rpos_q[IDX_W-1:0]),
      .rd_data (buf_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= RXS_IDLE;
         len_q  <= '0;
         rpos_q <= '0;
         rdy_q  <= 1'b0;
         ovf_q  <= 1'b0;
         ack_q  <= 1'b0;
         nak_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         ack_q <= 1'b0;
         nak_q <= 1'b0;
         irq_q <= 1'b0;
         if (mcu_rd && has_more) rpos_q <= rpos_q + CNT_W'(1);
         if (mcu_clr && rdy_q) begin
            rdy_q  <= 1'b0;
            rpos_q <= '0;
            len_q  <= '0;
         end
         unique case (st_q)
            RXS_IDLE: begin
               if (tok_out) begin
                  if (rdy_q) begin
                     st_q <= RXS_DROP;
                  end else begin
                     st_q  <= RXS_RECV;
                     len_q <= '0;
                     ovf_q <= 1'b0;
                  end
               end
            end
            RXS_RECV: begin
               if (eop) begin
                  st_q <= RXS_IDLE;
                  if (err || ovf_q) begin
                     len_q <= '0;
                  end else begin
                     ack_q <= 1'b1;
                     rdy_q <= 1'b1;
                     irq_q <= 1'b1;
                  end
               end else if (byte_valid) begin
                  if (store) len_q <= len_q + CNT_W'(1);
                  else       ovf_q <= 1'b1;
               end
            end
            RXS_DROP: begin
               if (eop) begin
                  st_q <= RXS_IDLE;
                  if (!err) nak_q <= 1'b1;
               end
            end
            default: st_q <= RXS_IDLE;
         endcase
      end
   end

   assign mcu_rdata = has_more ? buf_rd : '0;
   assign ready     = rdy_q;
   assign count     = len_q;
   assign ack       = ack_q;
   assign nak       = nak_q;
   assign irq       = irq_q;

   assert_ack_with_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |-> rdy_q && irq_q && !nak_q);
   assert_bad_no_hs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RXS_RECV && eop && (err || ovf_q)) |=>
         (!ack_q && !nak_q && !rdy_q && len_q == '0));
   assert_drop_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RXS_DROP && !mcu_clr) |=> $stable(len_q) && rdy_q);
   assert_nak_from_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      nak_q |-> $past(st_q == RXS_DROP));
   assert_rx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (len_q <= CNT_W'(DEPTH)) && (rpos_q <= len_q));

endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mcu_tx_wr,
   input  logic [DATA_W-1:0] mcu_tx_wdata,
   input  logic              mcu_tx_set,
   input  logic              mcu_rx_rd,
   output logic [DATA_W-1:0] mcu_rx_rdata,
   input  logic              mcu_rx_clr,
   output logic              tx_pkt_ready,
   output logic              rx_pkt_ready,
   output logic [CNT_W-1:0]  rx_count,
   output logic              irq,
   output logic              irq_tx,
   output logic              irq_rx,
   input  logic              tok_in,
   input  logic              tok_out,
   input  logic              host_ack,
   input  logic              rxd_valid,
   input  logic [DATA_W-1:0] rxd_data,
   input  logic              rxd_eop,
   input  logic              rxd_err,
   output logic              txd_valid,
   output logic [DATA_W-1:0] txd_data,
   output logic              txd_last,
   input  logic              txd_take,
   output logic              txd_zlp,
   output logic              hs_ack,
   output logic              hs_nak
);

   if (DEPTH < 2 || DEPTH > 1024) begin : g_bad_depth
      $error("usb_ep_handshake: DEPTH out of range 2..1024");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("usb_ep_handshake: DATA_W must be positive");
   end

   logic tx_nak, rx_nak;

   ep_tx_path #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .mcu_wr    (mcu_tx_wr),
      .mcu_wdata (mcu_tx_wdata),
      .mcu_set   (mcu_tx_set),
      .tok_in    (tok_in),
      .host_ack  (host_ack),
      .take      (txd_take),
      .ready     (tx_pkt_ready),
      .valid     (txd_valid),
      .data      (txd_data),
      .last      (txd_last),
      .zlp       (txd_zlp),
      .nak       (tx_nak),
      .irq       (irq_tx)
   );

   ep_rx_path #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .tok_out    (tok_out),
      .byte_valid (rxd_valid),
      .byte_data  (rxd_data),
      .eop        (rxd_eop),
      .err        (rxd_err),
      .mcu_rd     (mcu_rx_rd),
      .mcu_clr    (mcu_rx_clr),
      .mcu_rdata  (mcu_rx_rdata),
      .ready      (rx_pkt_ready),
      .count      (rx_count),
      .ack        (hs_ack),
      .nak        (rx_nak),
      .irq        (irq_rx)
   );

   // R11: one shared interrupt line for both causes
   assign irq    = irq_tx | irq_rx;
   assign hs_nak = tx_nak | rx_nak;

   assert_hs_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_ack && rx_nak));

endmodule

// File: tb/sim_usb_ep_handshake.sv
`timescale 1ns/1ps
module sim_usb_ep_handshake;
   localparam int DW = 8;
   localparam int DP = 4;
   localparam int CW = $clog2(DP + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic mcu_tx_wr = 0, mcu_tx_set = 0, mcu_rx_rd = 0, mcu_rx_clr = 0;
   logic [DW-1:0] mcu_tx_wdata = '0, rxd_data = '0;
   logic tok_in = 0, tok_out = 0, host_ack = 0, rxd_valid = 0, rxd_eop = 0, rxd_err = 0, txd_take = 0;
   logic [DW-1:0] mcu_rx_rdata, txd_data;
   logic tx_pkt_ready, rx_pkt_ready, irq, irq_tx, irq_rx, txd_valid, txd_last, txd_zlp, hs_ack, hs_nak;
   logic [CW-1:0] rx_count;

   int checks = 0, failures = 0, cyc = 0;

   always #2 clk = ~clk;

   usb_ep_handshake #(.DATA_W(DW), .DEPTH(DP)) u0 (
      .clk(clk), .rst_n(rst_n), .mcu_tx_wr(mcu_tx_wr), .mcu_tx_wdata(mcu_tx_wdata),
      .mcu_tx_set(mcu_tx_set), .mcu_rx_rd(mcu_rx_rd), .mcu_rx_rdata(mcu_rx_rdata),
      .mcu_rx_clr(mcu_rx_clr), .tx_pkt_ready(tx_pkt_ready), .rx_pkt_ready(rx_pkt_ready),
      .rx_count(rx_count), .irq(irq), .irq_tx(irq_tx), .irq_rx(irq_rx), .tok_in(tok_in),
      .tok_out(tok_out), .host_ack(host_ack), .rxd_valid(rxd_valid), .rxd_data(rxd_data),
      .rxd_eop(rxd_eop), .rxd_err(rxd_err), .txd_valid(txd_valid), .txd_data(txd_data),
      .txd_last(txd_last), .txd_take(txd_take), .txd_zlp(txd_zlp), .hs_ack(hs_ack), .hs_nak(hs_nak));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 50000) begin
         failures = failures + 1;
         $display("FAIL watchdog expired: actual=%0d expected<50000 cycles", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int p, input int i);
      return DW'(p * 37 + i * 11 + 5);
   endfunction

   task automatic pulse_in();
      tok_in = 1; tick(); tok_in = 0;
   endtask

   task automatic stream_check(input int len, input int p, input string req);
      for (int i = 0; i < len; i++) begin
         chk(req, "txd_valid", txd_valid, 1);
         chk(req, "txd_data", txd_data, pat(p, i));
         chk(req, "txd_last", txd_last, (i == len - 1));
         txd_take = 1; tick(); txd_take = 0;
      end
      chk(req, "txd_valid after last", txd_valid, 0);
   endtask

   task automatic send_out(input int n, input int p, input bit err);
      tok_out = 1; tick(); tok_out = 0;
      for (int i = 0; i < n; i++) begin
         rxd_valid = 1; rxd_data = pat(p, i); tick();
      end
      rxd_valid = 0;
      rxd_eop = 1; rxd_err = err; tick(); rxd_eop = 0; rxd_err = 0;
   endtask

   initial begin
      repeat (3) tick();
      // R1 reset state
      chk("R1", "tx_pkt_ready", tx_pkt_ready, 0);
      chk("R1", "rx_pkt_ready", rx_pkt_ready, 0);
      chk("R1", "rx_count", rx_count, 0);
      chk("R1", "outputs", {txd_valid, txd_zlp, hs_ack, hs_nak, irq, irq_tx, irq_rx}, 0);
      rst_n = 1; tick();

      // R4: IN with nothing ready
      pulse_in();
      chk("R4", "hs_nak", hs_nak, 1);
      chk("R4", "txd_valid", txd_valid, 0);
      tick();
      chk("R4", "hs_nak pulse width", hs_nak, 0);

      // Transmit sweep over every length
      for (int len = 0; len <= DP; len++) begin
         for (int i = 0; i < len; i++) begin
            mcu_tx_wr = 1; mcu_tx_wdata = pat(len, i); tick();
         end
         mcu_tx_wr = 0;
         mcu_tx_set = 1; tick(); mcu_tx_set = 0;
         chk("R2", "tx_pkt_ready set", tx_pkt_ready, 1);
         // R2: write while owned by USB side is ignored
         mcu_tx_wr = 1; mcu_tx_wdata = 8'hEE; tick(); mcu_tx_wr = 0;
         // R5: stray ACK before a send is ignored
         host_ack = 1; tick(); host_ack = 0;
         chk("R5", "stray ack keeps ready", tx_pkt_ready, 1);
         chk("R5", "stray ack no irq", irq_tx, 0);
         pulse_in();
         chk("R4", "no nak when ready", hs_nak, 0);
         if (len == 0) begin
            chk("R3", "txd_zlp", txd_zlp, 1);
            chk("R3", "zlp no data", txd_valid, 0);
            tick();
            chk("R3", "zlp pulse width", txd_zlp, 0);
         end else begin
            stream_check(len, len, "R3");
            if (len % 2 == 1) begin
               pulse_in();
               stream_check(len, len, "R6");
            end
         end
         host_ack = 1; tick(); host_ack = 0;
         chk("R5", "irq_tx", irq_tx, 1);
         chk("R11", "irq from tx", irq, 1);
         chk("R5", "tx_pkt_ready cleared", tx_pkt_ready, 0);
         tick();
         chk("R5", "irq_tx pulse width", irq_tx, 0);
      end
      // R5: emptied buffer -> next IN is NAKed, not a resend
      pulse_in();
      chk("R5", "nak after release", hs_nak, 1);
      tick();

      // Receive sweep: lengths 0..DP+1, with and without error
      for (int n = 0; n <= DP + 1; n++) begin
         for (int e = 0; e < 2; e++) begin
            bit good;
            good = (e == 0) && (n <= DP);
            send_out(n, n + 10 * e, e[0]);
            chk(good ? "R7" : "R10", "hs_ack", hs_ack, good);
            chk("R10", "hs_nak", hs_nak, 0);
            chk(good ? "R7" : "R10", "rx_pkt_ready", rx_pkt_ready, good);
            chk("R7", "irq_rx", irq_rx, good);
            chk("R11", "irq from rx", irq, good);
            chk(good ? "R7" : "R10", "rx_count", rx_count, good ? n : 0);
            tick();
            chk("R7", "irq_rx pulse width", irq_rx, 0);
            if (good) begin
               send_out(2, 99, 1'b0);
               chk("R9", "hs_nak busy", hs_nak, 1);
               chk("R9", "no ack busy", hs_ack, 0);
               chk("R9", "count kept", rx_count, n);
               send_out(1, 77, 1'b1);
               chk("R10", "errored drop silent", hs_nak, 0);
               for (int i = 0; i < n; i++) begin
                  chk("R8", "mcu_rx_rdata", mcu_rx_rdata, pat(n, i));
                  mcu_rx_rd = 1; tick(); mcu_rx_rd = 0;
               end
               chk("R8", "rdata after end", mcu_rx_rdata, 0);
               mcu_rx_clr = 1; tick(); mcu_rx_clr = 0;
               chk("R8", "rx ready cleared", rx_pkt_ready, 0);
               chk("R8", "rx count cleared", rx_count, 0);
            end
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule